// File: doc/BRIEF.md
# At-Speed Launch and Capture Clock Controller

This block sequences a scan chain through one delay-fault test pattern. While the test vector is loaded, it holds the scan enable high and passes a slow shift clock. It then releases a launch pulse and a capture pulse that are exactly one fast-clock period apart. The whole controller runs on the fast clock. The slow scan clock and the at-speed pulses are both delivered as a one-cycle synchronous enable, `clkEn`, that the scan cells sample on the fast clock. No combinational clock gating is used.

Two timing modes are supported. In launch-on-shift, the final shift of the chain is itself the launch, and the scan enable drops in the capture cycle that follows. In launch-on-capture, all shifts complete and the scan enable falls. A programmable settling gap, counted in slow periods, passes with the scan enable low. Both pulses are then functional pulses. In both modes the pulse pair is cut out by a five-stage window register loaded with the sequence 0,0,1,1,0. This gives two quiet lead-in cycles, then exactly two enabled fast cycles. A phase output reports the current step so that a test environment can follow the sequence.

Top module: `atspeed_clk_ctrl`

## Requirements
- R1: After reset, and whenever the block is idle, `phase` is 0 (idle), `scanEn` is 0 and `clkEn` is 0.
- R2: `start` is accepted only while idle. It latches `modeLos`, `shiftLen` and `deadLen`. A `start` pulse seen while a sequence is running is ignored and does not change the running sequence.
- R3: During shifting, `scanEn` is 1 and `clkEn` is high for one fast cycle every `SLOW_DIV` fast cycles. The j-th shift pulse falls in fast cycle j*`SLOW_DIV` after the clock edge that accepted `start`.
- R4: With N = `shiftLen`, where 0 counts as 1, launch-on-capture (`modeLos`=0) issues N slow shift pulses and launch-on-shift (`modeLos`=1) issues N-1. Every sequence therefore gives N-1 or N slow pulses plus two fast pulses.
- R5: In launch-on-capture, after the last shift, `scanEn` and `clkEn` stay 0 for D slow periods, where D = `deadLen` and 0 counts as 1.
- R6: The at-speed window is two cycles without a pulse, then `clkEn` high in exactly two consecutive fast cycles (launch, then capture), then idle in the next cycle.
- R7: In launch-on-shift, `scanEn` stays 1 through the lead-in and launch cycles and is 0 in the capture cycle.
- R8: In launch-on-capture, `scanEn` is 0 from the end of shifting through the dead time, lead-in, launch and capture.
- R9: The `phase` encoding is 0 idle, 1 shift, 2 dead, 3 launch and 4 capture. The lead-in cycles report 1 in launch-on-shift and 2 in launch-on-capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast (at-speed) clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin one pattern sequence (taken only when idle) |
| modeLos | input | 1 | 1 = launch-on-shift, 0 = launch-on-capture |
| shiftLen | input | CNT_W | Shift count N (0 treated as 1) |
| deadLen | input | DEAD_W | Dead time in slow periods (0 treated as 1) |
| scanEn | output | 1 | Scan enable to the chain multiplexers |
| clkEn | output | 1 | One-cycle clock enable for the scan cells |
| phase | output | 3 | Current step: 0 idle, 1 shift, 2 dead, 3 launch, 4 capture |

## Verification
The hardest situations to reach are the length boundaries of the two modes. One is launch-on-shift with a shift count of one, where no slow shift happens and the window opens straight from idle. The other is launch-on-capture with zero lengths, which must clamp to one shift and one dead period. The bench drives both directly and compares every fast cycle of each sequence against a cycle map derived from the requirements. A second `start`, carrying different settings, is injected in the middle of a running sequence, and the full trace must still match the first sequence's map.

// File: rtl/atspeed_pkg.sv
package atspeed_pkg;

  // Number of stages in the at-speed window register
  localparam int WIN_LEN = 5;
  // Bit i is the gate value in window cycle i: 0,0,1,1,0
  localparam logic [WIN_LEN-1:0] WIN_PATTERN = 5'b01100;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_SHIFT   = 3'd1,
    PH_DEAD    = 3'd2,
    PH_LAUNCH  = 3'd3,
    PH_CAPTURE = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SHIFT,
    ST_DEAD,
    ST_WIN
  } seq_state_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic divClear;  // restart the slow-clock divider
    logic winLoad;   // load the window register
    logic inShift;
    logic inDead;
    logic inWin;
    logic los;       // latched mode: launch-on-shift
  } ctrl_strobe_t;

endpackage

// File: rtl/atspeed_ctrl.sv
module atspeed_ctrl
  import atspeed_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int DEAD_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeLos,
  input  logic [CNT_W-1:0]  shiftLen,
  input  logic [DEAD_W-1:0] deadLen,
  input  logic              tick,
  input  logic              winLast,
  output ctrl_strobe_t      strobe
);

  seq_state_e stateQ, stateD;
  logic [CNT_W-1:0]  remShiftQ, remShiftD;
  logic [DEAD_W-1:0] remDeadQ, remDeadD;
  logic              losQ, losD;

  logic [CNT_W-1:0]  nEff;
  logic [CNT_W-1:0]  firstShifts;
  logic [DEAD_W-1:0] dEff;
  logic              winLoad;
  logic              divClear;

  // Clamp lengths to a minimum of one
  always_comb begin
    nEff        = (shiftLen == '0) ? CNT_W'(1) : shiftLen;
    dEff        = (deadLen == '0) ? DEAD_W'(1) : deadLen;
    firstShifts = modeLos ? (nEff - CNT_W'(1)) : nEff;
  end

  always_comb begin
    stateD    = stateQ;
    remShiftD = remShiftQ;
    remDeadD  = remDeadQ;
    losD      = losQ;
    winLoad   = 1'b0;
    divClear  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (start) begin
          losD      = modeLos;
          remShiftD = firstShifts;
          remDeadD  = dEff;
          divClear  = 1'b1;
          if (firstShifts == '0) begin
            stateD  = ST_WIN;
            winLoad = 1'b1;
          end else begin
            stateD = ST_SHIFT;
          end
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          remShiftD = remShiftQ - CNT_W'(1);
          if (remShiftQ == CNT_W'(1)) begin
            if (losQ) begin
              stateD  = ST_WIN;
              winLoad = 1'b1;
            end else begin
              stateD = ST_DEAD;
            end
          end
        end
      end
      ST_DEAD: begin
        if (tick) begin
          remDeadD = remDeadQ - DEAD_W'(1);
          if (remDeadQ == DEAD_W'(1)) begin
            stateD  = ST_WIN;
            winLoad = 1'b1;
          end
        end
      end
      ST_WIN: begin
        if (winLast) stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ    <= ST_IDLE;
      remShiftQ <= '0;
      remDeadQ  <= '0;
      losQ      <= 1'b0;
    end else begin
      stateQ    <= stateD;
      remShiftQ <= remShiftD;
      remDeadQ  <= remDeadD;
      losQ      <= losD;
    end
  end

  always_comb begin
    strobe.divClear = divClear;
    strobe.winLoad  = winLoad;
    strobe.inShift  = (stateQ == ST_SHIFT);
    strobe.inDead   = (stateQ == ST_DEAD);
    strobe.inWin    = (stateQ == ST_WIN);
    strobe.los      = losQ;
  end

endmodule

// File: rtl/atspeed_dp.sv
module atspeed_dp
  import atspeed_pkg::*;
#(
  parameter int SLOW_DIV = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output logic         tick,
  output logic         winLast,
  output logic         scanEn,
  output logic         clkEn,
  output phase_e       phase
);

  localparam int DIV_W = (SLOW_DIV > 2) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_TOP = DIV_W'(SLOW_DIV - 1);

  logic [DIV_W-1:0]   divCnt;
  logic [WIN_LEN-1:0] winQ;
  logic               winLead;
  logic               gateNow;

  // Slow scan clock as a periodic enable on the fast clock
  assign tick = (divCnt == DIV_TOP);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                divCnt <= '0;
    else if (strobe.divClear) divCnt <= '0;
    else if (tick)            divCnt <= '0;
    else                      divCnt <= divCnt + DIV_W'(1);
  end

  // Window shift register: each stage loads its pattern bit, then takes
  // the value of the stage above; the top stage fills with zero.
  for (genvar gi = 0; gi < WIN_LEN; gi++) begin : g_win
    if (gi == WIN_LEN - 1) begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               winQ[gi] <= 1'b0;
        else if (strobe.winLoad) winQ[gi] <= WIN_PATTERN[gi];
        else                     winQ[gi] <= 1'b0;
      end
    end else begin : g_mid
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)               winQ[gi] <= 1'b0;
        else if (strobe.winLoad) winQ[gi] <= WIN_PATTERN[gi];
        else                     winQ[gi] <= winQ[gi+1];
      end
    end
  end

  assign gateNow = winQ[0];
  assign winLead = |winQ[WIN_LEN-1:1];
  assign winLast = gateNow & ~winLead;

  always_comb begin
    clkEn  = (strobe.inShift & tick) | (strobe.inWin & gateNow);
    scanEn = strobe.inShift | (strobe.inWin & strobe.los & winLead);
    if (strobe.inShift)     phase = PH_SHIFT;
    else if (strobe.inDead) phase = PH_DEAD;
    else if (strobe.inWin) begin
      if (gateNow & winQ[1]) phase = PH_LAUNCH;
      else if (gateNow)      phase = PH_CAPTURE;
      else if (strobe.los)   phase = PH_SHIFT;
      else                   phase = PH_DEAD;
    end else                 phase = PH_IDLE;
  end

endmodule

// File: rtl/atspeed_clk_ctrl.sv
module atspeed_clk_ctrl
  import atspeed_pkg::*;
#(
  parameter int SLOW_DIV = 4,
  parameter int CNT_W    = 8,
  parameter int DEAD_W   = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              modeLos,
  input  logic [CNT_W-1:0]  shiftLen,
  input  logic [DEAD_W-1:0] deadLen,
  output logic              scanEn,
  output logic              clkEn,
  output logic [2:0]        phase
);

  ctrl_strobe_t strobe;
  logic         tick;
  logic         winLast;
  phase_e       phaseInt;

  atspeed_ctrl #(.CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .modeLos(modeLos),
    .shiftLen(shiftLen), .deadLen(deadLen), .tick(tick),
    .winLast(winLast), .strobe(strobe)
  );

  atspeed_dp #(.SLOW_DIV(SLOW_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tick(tick),
    .winLast(winLast), .scanEn(scanEn), .clkEn(clkEn), .phase(phaseInt)
  );

  assign phase = phaseInt;

endmodule

// File: rtl/atspeed_checker.sv
module atspeed_checker
  import atspeed_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       scanEn,
  input logic       clkEn,
  input logic [2:0] phase
);

  AST_SHIFT_SE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_SHIFT) |-> scanEn); // R3
  AST_DEAD_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_DEAD) |-> (!scanEn && !clkEn)); // R5
  AST_LAUNCH_TO_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LAUNCH) |=> (phase == PH_CAPTURE)); // R6
  AST_CAPTURE_PAIRED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CAPTURE) |-> ($past(clkEn) && clkEn)); // R6
  AST_CAPTURE_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CAPTURE) |=> (phase == PH_IDLE)); // R6
  AST_CAPTURE_SE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_CAPTURE) |-> !scanEn); // R7
  AST_LAUNCH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_LAUNCH) |-> clkEn); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> (!scanEn && !clkEn)); // R1
  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (phase <= 3'd4)); // R9

endmodule

bind atspeed_clk_ctrl atspeed_checker u_checker (
  .clk(clk), .rstN(rstN), .scanEn(scanEn), .clkEn(clkEn), .phase(phase)
);

// File: tb/atspeed_clk_ctrl_tb.sv
`timescale 1ns/1ps
module atspeed_clk_ctrl_tb;

  localparam int SLOW_DIV = 4;
  localparam int CNT_W    = 8;
  localparam int DEAD_W   = 4;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic              modeLos = 1'b0;
  logic [CNT_W-1:0]  shiftLen = '0;
  logic [DEAD_W-1:0] deadLen = '0;
  logic              scanEn;
  logic              clkEn;
  logic [2:0]        phase;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  atspeed_clk_ctrl #(.SLOW_DIV(SLOW_DIV), .CNT_W(CNT_W), .DEAD_W(DEAD_W)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .modeLos(modeLos),
    .shiftLen(shiftLen), .deadLen(deadLen),
    .scanEn(scanEn), .clkEn(clkEn), .phase(phase)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Region codes: 0 idle, 1 shift, 2 dead, 3 lead-in, 4 launch, 5 capture
  task automatic runCase(input string name, input bit mode, input int n,
                         input int d, input bit intrude);
    int nEff, dEff, k, launchC, last, pulses, misses;
    nEff = (n == 0) ? 1 : n;
    dEff = (d == 0) ? 1 : d;
    k = mode ? nEff - 1 : nEff;                 // R4
    launchC = (k + (mode ? 0 : dEff)) * SLOW_DIV + 3;
    last = launchC + 3;
    pulses = 0;
    misses = 0;
    @(negedge clk);
    modeLos = mode; shiftLen = CNT_W'(n); deadLen = DEAD_W'(d); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c <= last; c++) begin
      int region, eClk, eSe, ePh, badBefore;
      string tClk, tSe;
      if (c > 1) @(negedge clk);
      if (c <= k * SLOW_DIV)       region = 1;
      else if (c < launchC - 2)    region = 2;
      else if (c < launchC)        region = 3;
      else if (c == launchC)       region = 4;
      else if (c == launchC + 1)   region = 5;
      else                         region = 0;
      case (region)
        1: begin eClk = (c % SLOW_DIV == 0); eSe = 1; ePh = 1; tClk = "R3"; tSe = "R3"; end
        2: begin eClk = 0; eSe = 0; ePh = 2; tClk = "R5"; tSe = "R8"; end
        3: begin eClk = 0; eSe = mode; ePh = mode ? 1 : 2; tClk = "R6"; tSe = mode ? "R7" : "R8"; end
        4: begin eClk = 1; eSe = mode; ePh = 3; tClk = "R6"; tSe = mode ? "R7" : "R8"; end
        5: begin eClk = 1; eSe = 0; ePh = 4; tClk = "R6"; tSe = mode ? "R7" : "R8"; end
        default: begin eClk = 0; eSe = 0; ePh = 0; tClk = "R6"; tSe = "R1"; end
      endcase
      badBefore = bad;
      chk(clkEn == eClk, tClk, {name, " clkEn"}, clkEn, eClk);
      chk(scanEn == eSe, tSe, {name, " scanEn"}, scanEn, eSe);
      chk(phase == ePh, "R9", {name, " phase"}, phase, ePh);
      if (bad != badBefore) misses++;
      if (clkEn) pulses++;
      if (intrude && c == 2) begin
        start = 1'b1; modeLos = ~mode; shiftLen = 8'd7; deadLen = 4'd5;
      end
      if (intrude && c == 3) start = 1'b0;
    end
    chk(pulses == k + 2, "R4", {name, " pulse count"}, pulses, k + 2);
    if (intrude) chk(misses == 0, "R2", {name, " busy start ignored"}, misses, 0);
  endtask

  task automatic resetCase();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase == 3'd0 && scanEn == 1'b0 && clkEn == 1'b0, "R1", "in reset",
        {29'd0, phase}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(phase == 3'd0, "R1", "phase after reset", phase, 0);
    chk(scanEn == 1'b0, "R1", "scanEn after reset", scanEn, 0);
    chk(clkEn == 1'b0, "R1", "clkEn after reset", clkEn, 0);
  endtask

  initial begin
    resetCase();
    runCase("loc n3 d2", 1'b0, 3, 2, 1'b0);
    runCase("los n3", 1'b1, 3, 0, 1'b0);
    runCase("los n1", 1'b1, 1, 4, 1'b0);
    runCase("loc n0 d0", 1'b0, 0, 0, 1'b0);
    runCase("loc n1 d3", 1'b0, 1, 3, 1'b0);
    runCase("los n0", 1'b1, 0, 0, 1'b0);
    runCase("los n2 busy", 1'b1, 2, 0, 1'b1);
    runCase("loc n2 busy", 1'b0, 2, 1, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule